// File: doc/BRIEF.md
# Quarter-Sample Luma Interpolator

This block produces motion-compensated luma predictions at sub-sample positions. Each input beat carries a 6x6 window of 8-bit integer-position reference samples and a quarter-sample fractional offset for each axis. Each output beat carries the single predicted sample for that offset. Half-sample values come from a fixed six-tap filter run along rows or columns. The centre half position runs the filter in both directions. Quarter-sample values are the rounded-up mean of two neighbouring full or half values.

The window rows and columns are indexed 0..5. Index 2 is the integer sample the offset is measured from, and index 3 is the next integer sample to the right or below. Sample (r,c) sits at bits `[(r*6+c)*8 +: 8]` of `inWin`. The pipeline is three register stages deep. It accepts one window per clock while the output side is ready. When the output is stalled, the whole pipeline holds.

Top module: `qpel_interp`

## Requirements
- R1: With fracX=0 and fracY=0 the output equals the window sample G at (2,2), unfiltered.
- R2: With fracX=2 and fracY=0 the output is b = clip((E - 5F + 20G + 20H - 5I + J + 16) >>> 5), taken over row 2, columns 0..5.
- R3: With fracX=0 and fracY=2 the output is h, the same filter and rounding taken down column 2, rows 0..5.
- R4: Every filtered result is clipped to 0..255. A negative sum gives 0 and an oversized sum gives 255.
- R5: Quarter positions on one axis use (a + b + 1) >> 1. Horizontally, (1,0) averages G with b, and (3,0) averages sample (2,3) with b. Vertically, (0,1) averages G with h, and (0,3) averages sample (3,2) with h.
- R6: With fracX=2 and fracY=2 the output is j. Each of the six columns is filtered vertically without rounding or clipping. Those six sums are filtered horizontally, then rounded with +512, shifted by >>> 10 and clipped.
- R7: Mixed positions average j with a half sample. (2,1) uses b, and (2,3) uses s, the horizontal half of row 3. (1,2) uses h, and (3,2) uses m, the vertical half of column 3.
- R8: Diagonal positions (both fractions odd) average a horizontal half with a vertical half. fracY=1 selects b and fracY=3 selects s. fracX=1 selects h and fracX=3 selects m.
- R9: When not stalled, one window is accepted per clock. Its result appears on the output three clocks after acceptance.
- R10: `inReady` is high whenever `outValid` is low or `outReady` is high. While `outValid` is high and `outReady` is low, `outValid` and `outPix` hold. No result is lost or repeated, and results leave in input order.
- R11: During and right after reset, `outValid` is low and `inReady` is high. Windows in flight when reset is applied are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input window valid |
| inReady | output | 1 | Block can accept a window this cycle |
| inWin | input | 288 | 6x6 window of 8-bit samples, row-major |
| fracX | input | 2 | Horizontal quarter-sample offset |
| fracY | input | 2 | Vertical quarter-sample offset |
| outValid | output | 1 | Predicted sample valid |
| outReady | input | 1 | Consumer accepts the sample |
| outPix | output | 8 | Predicted sample |

## Verification
The bench aims at sign and range edges. A lone sample under a negative tap must clip to 0. A pair under the two positive taps must clip to 255 as a one-axis half, yet give 199 at the centre, where the intermediate values are not clipped. A design that clipped the vertical intermediates, or rounded them early, would give the wrong centre value.

Odd-valued sums catch rounding that truncates instead of rounding up. A one-sample spike placed in a known row or column catches a swapped operand choice between b/s, between h/m, or between (2,3)/(3,2) at quarter and diagonal positions.

Random back-pressure, a full stall and a reset taken mid-stream expose pipelines that drop results, duplicate them, change the held output, or leak old data after reset.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  // Six taps along each axis; the window is square.
  localparam int NTAP = 6;
  // Register stages between the input and output handshakes.
  localparam int LAT  = 3;

  // Strobes from the control to the datapath, one per pipeline stage.
  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
  } qpel_ctrl_t;
endpackage

// File: rtl/qpel_ctrl.sv
module qpel_ctrl
  import qpel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output logic       inReady,
  input  logic       outReady,
  output logic       outValid,
  output qpel_ctrl_t ctrl
);
  logic [LAT-1:0] validPipe;
  logic advance;

  assign advance  = !validPipe[LAT-1] || outReady;
  assign inReady  = advance;
  assign outValid = validPipe[LAT-1];

  assign ctrl.s1En = advance && inValid;
  assign ctrl.s2En = advance && validPipe[0];
  assign ctrl.s3En = advance && validPipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validPipe <= '0;
    else if (advance) validPipe <= {validPipe[LAT-2:0], inValid};
  end

  // R10
  empty_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  // R10
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);
endmodule

// File: rtl/qpel_datapath.sv
module qpel_datapath
  import qpel_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  qpel_ctrl_t                   ctrl,
  input  logic [NTAP*NTAP*PIX_W-1:0]   inWin,
  input  logic [1:0]                   fracX,
  input  logic [1:0]                   fracY,
  output logic [PIX_W-1:0]             outPix
);
  localparam int JW  = 2*PIX_W + 6;
  localparam int CTR = NTAP/2 - 1;
  localparam logic signed [JW-1:0] K5   = JW'(5);
  localparam logic signed [JW-1:0] K20  = JW'(20);
  localparam logic signed [JW-1:0] MAXV = JW'((1 << PIX_W) - 1);

  function automatic logic signed [JW-1:0] toAcc(input logic [PIX_W-1:0] p);
    return {{(JW-PIX_W){1'b0}}, p};
  endfunction

  function automatic logic signed [JW-1:0] tap6(
    input logic signed [JW-1:0] t0, t1, t2, t3, t4, t5);
    return t0 - K5*t1 + K20*t2 + K20*t3 - K5*t4 + t5;
  endfunction

  function automatic logic [PIX_W-1:0] rndClip(input logic signed [JW-1:0] x,
                                               input int sh);
    logic signed [JW-1:0] bias;
    logic signed [JW-1:0] t;
    bias = '0;
    bias[sh-1] = 1'b1;
    t = (x + bias) >>> sh;
    if (t < 0) return '0;
    else if (t > MAXV) return MAXV[PIX_W-1:0];
    else return t[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] avgUp(input logic [PIX_W-1:0] a,
                                             input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
    return s[PIX_W:1];
  endfunction

  // Window unpack
  logic [PIX_W-1:0] pix [NTAP][NTAP];
  for (genvar r = 0; r < NTAP; r++) begin : g_row
    for (genvar c = 0; c < NTAP; c++) begin : g_col
      assign pix[r][c] = inWin[(r*NTAP+c)*PIX_W +: PIX_W];
    end
  end

  // Stage 1: raw six-tap sums
  logic signed [JW-1:0] colSum [NTAP];
  logic signed [JW-1:0] rowSumA, rowSumB;
  always_comb begin
    for (int c = 0; c < NTAP; c++)
      colSum[c] = tap6(toAcc(pix[0][c]), toAcc(pix[1][c]), toAcc(pix[2][c]),
                       toAcc(pix[3][c]), toAcc(pix[4][c]), toAcc(pix[5][c]));
    rowSumA = tap6(toAcc(pix[CTR][0]), toAcc(pix[CTR][1]), toAcc(pix[CTR][2]),
                   toAcc(pix[CTR][3]), toAcc(pix[CTR][4]), toAcc(pix[CTR][5]));
    rowSumB = tap6(toAcc(pix[CTR+1][0]), toAcc(pix[CTR+1][1]), toAcc(pix[CTR+1][2]),
                   toAcc(pix[CTR+1][3]), toAcc(pix[CTR+1][4]), toAcc(pix[CTR+1][5]));
  end

  logic signed [JW-1:0] s1Col [NTAP];
  logic signed [JW-1:0] s1RowA, s1RowB;
  logic [PIX_W-1:0] s1G, s1Right, s1Below;
  logic [1:0] s1Fx, s1Fy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NTAP; c++) s1Col[c] <= '0;
      s1RowA <= '0; s1RowB <= '0;
      s1G <= '0; s1Right <= '0; s1Below <= '0;
      s1Fx <= '0; s1Fy <= '0;
    end else if (ctrl.s1En) begin
      for (int c = 0; c < NTAP; c++) s1Col[c] <= colSum[c];
      s1RowA  <= rowSumA;
      s1RowB  <= rowSumB;
      s1G     <= pix[CTR][CTR];
      s1Right <= pix[CTR][CTR+1];
      s1Below <= pix[CTR+1][CTR];
      s1Fx    <= fracX;
      s1Fy    <= fracY;
    end
  end

  // Stage 2: normalise the half samples, second pass for the centre
  logic signed [JW-1:0] centreSum;
  assign centreSum = tap6(s1Col[0], s1Col[1], s1Col[2], s1Col[3], s1Col[4], s1Col[5]);

  logic [PIX_W-1:0] s2HalfB, s2HalfS, s2HalfH, s2HalfM, s2HalfJ;
  logic [PIX_W-1:0] s2G, s2Right, s2Below;
  logic [1:0] s2Fx, s2Fy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2HalfB <= '0; s2HalfS <= '0; s2HalfH <= '0; s2HalfM <= '0; s2HalfJ <= '0;
      s2G <= '0; s2Right <= '0; s2Below <= '0;
      s2Fx <= '0; s2Fy <= '0;
    end else if (ctrl.s2En) begin
      s2HalfB <= rndClip(s1RowA, 5);
      s2HalfS <= rndClip(s1RowB, 5);
      s2HalfH <= rndClip(s1Col[CTR], 5);
      s2HalfM <= rndClip(s1Col[CTR+1], 5);
      s2HalfJ <= rndClip(centreSum, 10);
      s2G     <= s1G;
      s2Right <= s1Right;
      s2Below <= s1Below;
      s2Fx    <= s1Fx;
      s2Fy    <= s1Fy;
    end
  end

  // Stage 3: position select and quarter averaging
  logic [PIX_W-1:0] opA, opB, direct, minOp, maxOp, selPix;
  logic isAvg;

  always_comb begin
    isAvg  = 1'b1;
    direct = s2G;
    opA    = s2G;
    opB    = s2G;
    if (s2Fx == 2'd0 && s2Fy == 2'd0) begin
      isAvg = 1'b0;
    end else if (s2Fy == 2'd0) begin
      isAvg  = (s2Fx != 2'd2);
      direct = s2HalfB;
      opA    = (s2Fx == 2'd1) ? s2G : s2Right;
      opB    = s2HalfB;
    end else if (s2Fx == 2'd0) begin
      isAvg  = (s2Fy != 2'd2);
      direct = s2HalfH;
      opA    = (s2Fy == 2'd1) ? s2G : s2Below;
      opB    = s2HalfH;
    end else if (s2Fx == 2'd2 && s2Fy == 2'd2) begin
      isAvg  = 1'b0;
      direct = s2HalfJ;
    end else if (s2Fx == 2'd2) begin
      opA = s2HalfJ;
      opB = (s2Fy == 2'd1) ? s2HalfB : s2HalfS;
    end else if (s2Fy == 2'd2) begin
      opA = s2HalfJ;
      opB = (s2Fx == 2'd1) ? s2HalfH : s2HalfM;
    end else begin
      opA = (s2Fy == 2'd1) ? s2HalfB : s2HalfS;
      opB = (s2Fx == 2'd1) ? s2HalfH : s2HalfM;
    end
    minOp  = (opA < opB) ? opA : opB;
    maxOp  = (opA < opB) ? opB : opA;
    selPix = isAvg ? avgUp(opA, opB) : direct;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outPix <= '0;
    else if (ctrl.s3En) outPix <= selPix;
  end

  // R1
  int_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.s3En && s2Fx == 2'd0 && s2Fy == 2'd0 |=> outPix == $past(s2G));

  // R5
  avg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.s3En && isAvg |=> outPix >= $past(minOp) && outPix <= $past(maxOp));
endmodule

// File: rtl/qpel_interp.sv
module qpel_interp
  import qpel_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [NTAP*NTAP*PIX_W-1:0] inWin,
  input  logic [1:0]                 fracX,
  input  logic [1:0]                 fracY,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [PIX_W-1:0]           outPix
);
  qpel_ctrl_t ctrl;

  qpel_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .ctrl     (ctrl)
  );

  qpel_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .inWin  (inWin),
    .fracX  (fracX),
    .fracY  (fracY),
    .outPix (outPix)
  );

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> $stable(outPix));
endmodule

// File: tb/tb_qpel_interp.sv
module tb_qpel_interp;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 288;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [WB-1:0] inWin = '0;
  logic [1:0] fracX = '0, fracY = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outPix;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpel_interp dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inWin(inWin), .fracX(fracX), .fracY(fracY),
    .outValid(outValid), .outReady(outReady), .outPix(outPix)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int expPix [0:1023];
  int expReq [0:1023];
  int wrIdx = 0, rdIdx = 0;
  bit accepted, sawOut;
  bit randReady = 0;
  logic [31:0] seed = 32'h1234_5678;

  // {kind[3:0], fracX[1:0], fracY[1:0], expected[7:0]}
  localparam int NVEC = 22;
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    {4'd0, 2'd0, 2'd0, 8'd100},  // R1
    {4'd0, 2'd2, 2'd2, 8'd100},  // R6
    {4'd0, 2'd3, 2'd1, 8'd100},  // R8
    {4'd1, 2'd2, 2'd0, 8'd25},   // R2
    {4'd1, 2'd1, 2'd0, 8'd23},   // R5
    {4'd1, 2'd3, 2'd0, 8'd28},   // R5
    {4'd1, 2'd2, 2'd2, 8'd25},   // R6
    {4'd1, 2'd0, 2'd2, 8'd20},   // R3
    {4'd2, 2'd2, 2'd0, 8'd159},  // R2
    {4'd2, 2'd3, 2'd0, 8'd207},  // R5
    {4'd2, 2'd2, 2'd2, 8'd100},  // R6
    {4'd2, 2'd2, 2'd1, 8'd130},  // R7
    {4'd2, 2'd1, 2'd1, 8'd80},   // R8
    {4'd2, 2'd3, 2'd3, 8'd80},   // R8
    {4'd2, 2'd3, 2'd2, 8'd130},  // R7
    {4'd2, 2'd1, 2'd2, 8'd50},   // R7
    {4'd3, 2'd2, 2'd0, 8'd0},    // R4
    {4'd4, 2'd2, 2'd0, 8'd255},  // R4
    {4'd4, 2'd2, 2'd2, 8'd199},  // R6
    {4'd5, 2'd0, 2'd2, 8'd25},   // R3
    {4'd5, 2'd0, 2'd1, 8'd23},   // R5
    {4'd5, 2'd0, 2'd3, 8'd28}    // R5
  };
  localparam int VREQ [0:NVEC-1] = '{1,6,8,2,5,5,6,3,2,5,6,7,8,8,7,7,4,4,6,3,5,5};

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [WB-1:0] genWin(input int kind);
    logic [WB-1:0] w = '0;
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        int v = 0;
        case (kind)
          0: v = 100;
          1: v = 10*c;
          2: v = (r == 2 && c == 3) ? 255 : 0;
          3: v = (r == 2 && c == 1) ? 255 : 0;
          4: v = (r == 2 && (c == 2 || c == 3)) ? 255 : 0;
          default: v = 10*r;
        endcase
        w[(r*6+c)*8 +: 8] = 8'(v);
      end
    return w;
  endfunction

  function automatic int px(input logic [WB-1:0] w, input int r, input int c);
    return int'(w[(r*6+c)*8 +: 8]);
  endfunction

  function automatic int fir(input int a, b, c, d, e, f);
    return a - 5*b + 20*c + 20*d - 5*e + f;
  endfunction

  function automatic int clip(input int x);
    return (x < 0) ? 0 : (x > 255) ? 255 : x;
  endfunction

  function automatic int refModel(input logic [WB-1:0] w, input int fx, input int fy);
    int hb, hs, vh, vm, cj, g, rt, bl, v [6];
    hb = clip((fir(px(w,2,0),px(w,2,1),px(w,2,2),px(w,2,3),px(w,2,4),px(w,2,5)) + 16) >>> 5);
    hs = clip((fir(px(w,3,0),px(w,3,1),px(w,3,2),px(w,3,3),px(w,3,4),px(w,3,5)) + 16) >>> 5);
    for (int c = 0; c < 6; c++)
      v[c] = fir(px(w,0,c),px(w,1,c),px(w,2,c),px(w,3,c),px(w,4,c),px(w,5,c));
    vh = clip((v[2] + 16) >>> 5);
    vm = clip((v[3] + 16) >>> 5);
    cj = clip((fir(v[0],v[1],v[2],v[3],v[4],v[5]) + 512) >>> 10);
    g = px(w,2,2); rt = px(w,2,3); bl = px(w,3,2);
    if (fx == 0 && fy == 0) return g;
    if (fy == 0) return (fx == 2) ? hb : (((fx == 1 ? g : rt) + hb + 1) / 2);
    if (fx == 0) return (fy == 2) ? vh : (((fy == 1 ? g : bl) + vh + 1) / 2);
    if (fx == 2 && fy == 2) return cj;
    if (fx == 2) return (cj + (fy == 1 ? hb : hs) + 1) / 2;
    if (fy == 2) return (cj + (fx == 1 ? vh : vm) + 1) / 2;
    return ((fy == 1 ? hb : hs) + (fx == 1 ? vh : vm) + 1) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: evaluate handshakes just before the edge, return after the next negedge.
  task automatic step();
    if (randReady) outReady = nextRand() % 4 != 0;
    #1;
    accepted = inValid && inReady;
    sawOut = outValid;
    if (accepted) begin
      expPix[wrIdx % 1024] = refModel(inWin, int'(fracX), int'(fracY));
      wrIdx++;
    end
    if (outValid && outReady) begin
      if (rdIdx < wrIdx) begin
        check(int'(outPix) == expPix[rdIdx % 1024],
              $sformatf("R%0d", expReq[rdIdx % 1024]), int'(outPix), expPix[rdIdx % 1024]);
        rdIdx++;
      end else check(1'b0, "R10 spurious output", int'(outPix), -1);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [WB-1:0] w, input int fx, input int fy, input int req);
    inValid = 1'b1; inWin = w; fracX = 2'(fx); fracY = 2'(fy);
    expReq[wrIdx % 1024] = req;
    do step(); while (!accepted);
  endtask

  task automatic drain();
    inValid = 1'b0;
    randReady = 0;
    outReady = 1'b1;
    for (int i = 0; i < 20 && rdIdx < wrIdx; i++) step();
    check(rdIdx == wrIdx, "R10 drain count", rdIdx, wrIdx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9: watchdog expired, actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tableOut, stepsUsed, held;
    logic [WB-1:0] w;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(outValid == 1'b0, "R11 outValid in reset", int'(outValid), 0);
    check(inReady == 1'b1, "R11 inReady in reset", int'(inReady), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(outValid == 1'b0 && inReady == 1'b1, "R11 idle after reset", int'(outValid), 0);

    // Table of directed vectors; expected values double as model cross-checks
    for (int i = 0; i < NVEC; i++) begin
      w = genWin(int'(VEC[i][15:12]));
      tableOut = refModel(w, int'(VEC[i][11:10]), int'(VEC[i][9:8]));
      check(tableOut == int'(VEC[i][7:0]), $sformatf("R%0d table entry", VREQ[i]),
            tableOut, int'(VEC[i][7:0]));
      send(w, int'(VEC[i][11:10]), int'(VEC[i][9:8]), VREQ[i]);
    end
    drain();

    // R9 latency: output three clocks after acceptance
    send(genWin(2), 2, 2, 6);
    inValid = 1'b0;
    stepsUsed = 0;
    do begin step(); stepsUsed++; end while (!sawOut && stepsUsed < 10);
    check(stepsUsed == 3, "R9 latency", stepsUsed, 3);
    drain();

    // R9 throughput: back-to-back acceptance
    stepsUsed = 0;
    inValid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      inWin = genWin(i % 6); fracX = 2'(i % 4); fracY = 2'((i / 4) % 4);
      expReq[wrIdx % 1024] = 9;
      step();
      if (accepted) stepsUsed++;
    end
    check(stepsUsed == 10, "R9 one per clock", stepsUsed, 10);
    drain();

    // R10 full stall: three in flight, output held
    outReady = 1'b0;
    inValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      inWin = genWin(1); fracX = 2'(i % 4); fracY = 2'd0;
      expReq[wrIdx % 1024] = 10;
      step();
    end
    check(inReady == 1'b0, "R10 inReady low on stall", int'(inReady), 0);
    check(wrIdx - rdIdx == 3, "R10 in-flight count", wrIdx - rdIdx, 3);
    held = int'(outPix);
    for (int i = 0; i < 4; i++) step();
    check(outValid == 1'b1 && int'(outPix) == held, "R10 output held",
          int'(outPix), held);
    drain();

    // Random sweep with random back-pressure, all positions
    randReady = 1;
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < WB/32; k++) w[k*32 +: 32] = nextRand();
      send(w, int'(nextRand() % 4), int'(nextRand() % 4), 8);
    end
    drain();

    // R11 reset mid-stream discards in-flight work
    inValid = 1'b1;
    for (int i = 0; i < 2; i++) begin
      inWin = genWin(0); fracX = 2'd0; fracY = 2'd0;
      step();
    end
    rst_n = 1'b0;
    inValid = 1'b0;
    #1;
    check(outValid == 1'b0 && inReady == 1'b1, "R11 reset flushes", int'(outValid), 0);
    rdIdx = wrIdx;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      if (sawOut) check(1'b0, "R11 stale output after reset", int'(outPix), -1);
    end
    check(outValid == 1'b0, "R11 idle after flush", int'(outValid), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule